// File: doc/BRIEF.md
# Two-Tier Local Interrupt Controller

This block collects a set of local event pulses into sticky status flags and reduces them to one active-low interrupt line. Each flag is qualified twice: once by its own enable bit, held in an enable word whose bit positions line up one for one with the status word, and once more by a single global enable. The line is driven low only when some flag, its enable and the global enable are all set. All qualified flags are ORed onto that one line.

Software reaches the two words through a small register port with a strobe for reads, a strobe for writes and an address. Flags are cleared by writing ones to the status word. An auto-clear option can be set in the enable word. When it is set, each read of the status word also drops the global enable, which releases the interrupt line without a separate write. The read itself still returns the global enable as it stood before it was cleared.

Top module: `lirq_ctrl`

## Requirements
- R1: After reset both words read 0x0000_0000 and `irq_n_o` is high.
- R2: A one-cycle pulse on `evt_i[n]` sets status bit n, which then stays set. Bit 4 is reserved: it never sets, and it reads 0 in both words.
- R3: Writing the status word (address 0x0) clears each flag at bits 13..0 whose write-data bit is 1. A 0 leaves the flag unchanged. Bits 14 and 15 of a status write have no effect.
- R4: When a clearing write and a new pulse hit the same flag in the same cycle, the flag ends up set.
- R5: The enable word (address 0x4) is read/write. Bits 13..0 are the per-flag enables, with bit 4 always 0. Bit 14 is the global enable and bit 15 is auto-clear. Bits 31..16 read 0 in both words.
- R6: The status word reads flags in bits 13..0, the global enable in bit 14 and the auto-clear bit in bit 15.
- R7: `irq_n_o` is low exactly when the global enable is set and at least one flag is set together with its enable. It is registered, so it follows a change in flags or enables on the next clock edge.
- R8: A status read with auto-clear set returns the global enable unchanged and clears it at that clock edge. Without auto-clear, or on a read of the enable word, the global enable is left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | One-cycle event pulses, one per flag |
| addr_i | input | 4 | Register address: 0x0 status, 0x4 enable |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the same cycle as `rd_i`, otherwise 0 |
| irq_n_o | output | 1 | Interrupt line, active low, registered |

## Verification
Read data is combinational, so the bench samples `rdata_o` one time unit after raising `rd_i`, before that cycle's clock edge. A flag or enable change lands on the edge that takes the pulse or write. `irq_n_o` moves one edge after that. An event therefore reaches the line two edges after it is driven, and an enable write or auto-clear read reaches it one edge after the register changes. The bench drives and samples on falling edges. It checks the line both at the edge before the change is due, where it must still hold its old value, and at the edge where the change is due.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_ENAB = 2'd2
   } lirq_sel_e;
endpackage

// File: rtl/lirq_flags.sv
module lirq_flags #(
   parameter int unsigned          N_SRC    = 14,
   parameter logic [N_SRC-1:0]     SRC_MASK = 14'h3FEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flags_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_bit
      if (SRC_MASK[i]) begin : g_live
         logic flag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q <= 1'b0;
            else        flag_q <= evt_i[i] | (flag_q & ~clr_i[i]);
         end
         assign flags_o[i] = flag_q;

         // R4
         evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> flags_o[i]);
         // R3
         w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !flags_o[i]);
      end else begin : g_tied
         logic unused_tie;
         assign unused_tie = evt_i[i] ^ clr_i[i];
         assign flags_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs #(
   parameter int unsigned          N_SRC    = 14,
   parameter logic [N_SRC-1:0]     SRC_MASK = 14'h3FEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr_i,
   input  logic [N_SRC-1:0] wen_i,
   input  logic             wgie_i,
   input  logic             wacl_i,
   input  logic             stat_rd_i,
   output logic [N_SRC-1:0] en_o,
   output logic             gie_o,
   output logic             acl_o
);
   logic [N_SRC-1:0] en_q;
   logic             gie_q;
   logic             acl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         gie_q <= 1'b0;
         acl_q <= 1'b0;
      end else if (en_wr_i) begin
         en_q  <= wen_i & SRC_MASK;
         gie_q <= wgie_i;
         acl_q <= wacl_i;
      end else if (stat_rd_i && acl_q) begin
         gie_q <= 1'b0;
      end
   end

   assign en_o  = en_q;
   assign gie_o = gie_q;
   assign acl_o = acl_q;

   // R8
   autoclr_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && acl_o && !en_wr_i) |=> !gie_o);
   // R8
   gie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_wr_i && !(stat_rd_i && acl_o)) |=> $stable(gie_o));
endmodule

// File: rtl/lirq_out.sv
module lirq_out #(
   parameter int unsigned N_SRC = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] flags_i,
   input  logic [N_SRC-1:0] en_i,
   input  logic             gie_i,
   output logic             irq_n_o
);
   logic any_hit;
   logic irq_n_q;

   assign any_hit = |(flags_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_q <= 1'b1;
      else        irq_n_q <= ~(gie_i & any_hit);
   end

   assign irq_n_o = irq_n_q;

   // R7
   gie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_i |=> irq_n_o);
   // R7
   no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags_i & en_i) == '0) |=> irq_n_o);
endmodule

// File: rtl/lirq_ctrl.sv
module lirq_ctrl #(
   parameter int unsigned      DATA_W    = 32,
   parameter int unsigned      ADDR_W    = 4,
   parameter int unsigned      N_SRC     = 14,
   parameter logic [N_SRC-1:0] SRC_MASK  = 14'h3FEF,
   parameter int unsigned      GIE_POS   = 14,
   parameter int unsigned      ACL_POS   = 15,
   parameter int unsigned      STAT_ADDR = 0,
   parameter int unsigned      ENAB_ADDR = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  evt_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_n_o
);
   import lirq_pkg::*;

   localparam int unsigned TOP_POS = (GIE_POS > ACL_POS) ? GIE_POS : ACL_POS;

   if (DATA_W <= TOP_POS) begin : g_bad_width
      $error("lirq_ctrl: DATA_W too narrow for control bits");
   end
   if (N_SRC > GIE_POS || N_SRC > ACL_POS) begin : g_bad_src
      $error("lirq_ctrl: flag field overlaps control bits");
   end
   if (GIE_POS == ACL_POS || STAT_ADDR == ENAB_ADDR) begin : g_bad_map
      $error("lirq_ctrl: register map collision");
   end

   lirq_sel_e        sel;
   logic [N_SRC-1:0] clr_vec;
   logic [N_SRC-1:0] flags;
   logic [N_SRC-1:0] en;
   logic             gie;
   logic             acl;
   logic             unused_wd;

   always_comb begin
      if (addr_i == ADDR_W'(STAT_ADDR))      sel = SEL_STAT;
      else if (addr_i == ADDR_W'(ENAB_ADDR)) sel = SEL_ENAB;
      else                                   sel = SEL_NONE;
   end

   assign clr_vec   = (wr_i && sel == SEL_STAT) ? wdata_i[N_SRC-1:0] : '0;
   assign unused_wd = ^wdata_i;

   lirq_flags #(.N_SRC(N_SRC), .SRC_MASK(SRC_MASK)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .clr_i  (clr_vec),
      .flags_o(flags)
   );

   lirq_regs #(.N_SRC(N_SRC), .SRC_MASK(SRC_MASK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr_i  (wr_i && sel == SEL_ENAB),
      .wen_i    (wdata_i[N_SRC-1:0]),
      .wgie_i   (wdata_i[GIE_POS]),
      .wacl_i   (wdata_i[ACL_POS]),
      .stat_rd_i(rd_i && sel == SEL_STAT),
      .en_o     (en),
      .gie_o    (gie),
      .acl_o    (acl)
   );

   lirq_out #(.N_SRC(N_SRC)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .flags_i(flags),
      .en_i   (en),
      .gie_i  (gie),
      .irq_n_o(irq_n_o)
   );

   always_comb begin
      rdata_o = '0;
      if (rd_i && sel != SEL_NONE) begin
         rdata_o[N_SRC-1:0] = (sel == SEL_STAT) ? flags : en;
         rdata_o[GIE_POS]   = gie;
         rdata_o[ACL_POS]   = acl;
      end
   end

   // R5
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[DATA_W-1:TOP_POS+1] == '0);
endmodule

// File: tb/sim_lirq_ctrl.sv
module sim_lirq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] evt = '0;
   logic [3:0]  addr = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [3:0] A_ST = 4'h0;
   localparam logic [3:0] A_EN = 4'h4;

   always #5 clk = ~clk;

   lirq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr), .wr_i(wr),
      .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      step();
      wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      step();
      rd = 1'b0;
   endtask

   task automatic pulse(input logic [13:0] v);
      evt = v;
      step();
      evt = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      do_reset();
      chk("R1 irq_n after reset", {31'b0, irq_n}, 32'h1);
      rd_reg(A_ST, d); chk("R1 status after reset", d, 32'h0);
      rd_reg(A_EN, d); chk("R1 enable after reset", d, 32'h0);
   endtask

   task automatic t_latch();
      logic [31:0] d;
      do_reset();
      pulse(14'h0014);
      rd_reg(A_ST, d); chk("R2 latch, bit 4 reserved", d, 32'h0000_0004);
      step(); step(); step();
      rd_reg(A_ST, d); chk("R2 flag stays set", d, 32'h0000_0004);
      chk("R7 no enable keeps line high", {31'b0, irq_n}, 32'h1);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      do_reset();
      pulse(14'h0003);
      wr_reg(A_ST, 32'hFFFF_C000);
      rd_reg(A_ST, d); chk("R3 zero bits leave flags", d, 32'h0000_0003);
      rd_reg(A_EN, d); chk("R3 status write ignores bits 15:14", d, 32'h0);
      wr_reg(A_ST, 32'h0000_0001);
      rd_reg(A_ST, d); chk("R3 one clears flag", d, 32'h0000_0002);
   endtask

   task automatic t_same();
      logic [31:0] d;
      do_reset();
      pulse(14'h0020);
      evt = 14'h0020;
      wr_reg(A_ST, 32'h0000_0020);
      evt = '0;
      rd_reg(A_ST, d); chk("R4 event beats clear", d, 32'h0000_0020);
   endtask

   task automatic t_enreg();
      logic [31:0] d;
      do_reset();
      wr_reg(A_EN, 32'hFFFF_FFFF);
      rd_reg(A_EN, d); chk("R5 enable readback", d, 32'h0000_FFEF);
      rd_reg(A_ST, d); chk("R6 status shows gie and acl", d, 32'h0000_C000);
      rd_reg(A_EN, d); chk("R8 status read cleared gie", d, 32'h0000_BFEF);
   endtask

   task automatic t_irq();
      do_reset();
      wr_reg(A_EN, 32'h0000_0009);
      pulse(14'h0009);
      step();
      chk("R7 gie off keeps line high", {31'b0, irq_n}, 32'h1);
      wr_reg(A_EN, 32'h0000_4009);
      chk("R7 line not yet low", {31'b0, irq_n}, 32'h1);
      step();
      chk("R7 line low one edge later", {31'b0, irq_n}, 32'h0);
      wr_reg(A_ST, 32'h0000_0001);
      step();
      chk("R7 other flag holds line low", {31'b0, irq_n}, 32'h0);
      wr_reg(A_ST, 32'h0000_0008);
      chk("R7 line still low at clear edge", {31'b0, irq_n}, 32'h0);
      step();
      chk("R7 line released", {31'b0, irq_n}, 32'h1);
      pulse(14'h0008);
      step();
      chk("R7 line low again", {31'b0, irq_n}, 32'h0);
      wr_reg(A_EN, 32'h0000_0009);
      step();
      chk("R7 gie cleared releases line", {31'b0, irq_n}, 32'h1);
   endtask

   task automatic t_autoclr();
      logic [31:0] d;
      do_reset();
      pulse(14'h0001);
      wr_reg(A_EN, 32'h0000_4001);
      step();
      chk("R7 line low", {31'b0, irq_n}, 32'h0);
      rd_reg(A_ST, d); chk("R8 no auto-clear read", d, 32'h0000_4001);
      rd_reg(A_EN, d); chk("R8 gie kept without auto-clear", d, 32'h0000_4001);
      step();
      chk("R8 line still low", {31'b0, irq_n}, 32'h0);
      wr_reg(A_EN, 32'h0000_C001);
      rd_reg(A_EN, d); chk("R8 enable read does not clear", d, 32'h0000_C001);
      rd_reg(A_ST, d); chk("R8 read returns gie before clear", d, 32'h0000_C001);
      chk("R8 line low at clearing edge", {31'b0, irq_n}, 32'h0);
      step();
      chk("R8 line released after auto-clear", {31'b0, irq_n}, 32'h1);
      rd_reg(A_EN, d); chk("R8 gie cleared", d, 32'h0000_8001);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_latch();
      t_w1c();
      t_same();
      t_enreg();
      t_irq();
      t_autoclr();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule